// File: doc/BRIEF.md
# Static Memory Read Timing Generator

This block produces the read waveforms for an external asynchronous static memory bus with several chip-select lines. Each chip-select line has its own timing record: a setup and a pulse length for the read strobe, a setup and a pulse length for the chip-select strobe, and one total cycle length that both strobes share. All values count system clock cycles. Hold times are never written. Each strobe's hold is whatever remains of the cycle after its setup and pulse.

A read request carries an address and a chip-select index and uses a valid/ready handshake. The block puts the address on the bus for the whole cycle. It drives the read strobe and the addressed chip-select line low, each within its own window, and samples the memory data on the last clock of the read pulse. The sampled word is returned with a one-clock valid pulse. A request can be accepted on the final clock of the current cycle, so reads run back to back with no idle clock. When setups and holds are zero, the strobes stay low across consecutive reads to the same memory. When the next read goes to a different memory and the two chip-select windows would touch, the block inserts one idle clock between them.

Top module: `stm_read_gen`

## Requirements
- R1: After reset, the read strobe and every chip-select line are high (inactive), `req_ready` is 1, `rd_valid` is 0 and `cfg_err` is 0. Every chip-select line is set up with setup 0, pulse 0 and cycle 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the clock that follows, the cycle's clock 0 begins and `mem_addr` shows the request address. The address stays unchanged for all cycle clocks. `req_ready` is 0 during the cycle except on its last clock.
- R3: The read strobe `mem_rd_n` is 0 exactly on cycle clocks t with S_rd <= t < S_rd + P_rd.
- R4: Only the addressed line of `mem_cs_n` goes low, exactly on cycle clocks t with S_cs <= t < S_cs + P_cs. At no time is more than one chip-select line low.
- R5: A cycle lasts exactly C clocks, where C is the programmed cycle value. Each strobe's hold is therefore C minus its setup minus its effective pulse. When no request is pending, all strobes return high after the cycle.
- R6: A programmed pulse value of 0 acts as a pulse of 1 clock for either strobe.
- R7: `mem_rdata` is sampled at the rising edge that ends the last clock of the read pulse. In the clock after that edge, `rd_valid` is 1 for one clock and `rd_data` holds the sampled word.
- R8: A request that is pending on a cycle's last clock starts its clock 0 directly after that cycle. With zero setup and zero hold on the same chip select, the read strobe and that chip-select line stay low without a break across both cycles.
- R9: If the next request targets a different chip select, the previous line is low on its cycle's last clock, and the new line's setup is 0, then one turnaround clock is inserted. During that clock all strobes are high and the address is unchanged.
- R10: A configuration write (`cfg_we`=1) is rejected when the cycle value is smaller than setup plus effective pulse for either strobe. A rejected write sets `cfg_err` to 1 and leaves the stored record unchanged. An accepted write, including one where cycle equals setup plus pulse, clears `cfg_err`.
- R11: Each chip-select line keeps its own timing record. A read uses only the record of its own line, and setup and pulse values up to 63 and cycle values up to 127 are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Chip-select line whose record is written |
| cfg_rd_setup | input | 6 | Read-strobe setup, clocks |
| cfg_rd_pulse | input | 6 | Read-strobe pulse, clocks (0 acts as 1) |
| cfg_cs_setup | input | 6 | Chip-select setup, clocks |
| cfg_cs_pulse | input | 6 | Chip-select pulse, clocks (0 acts as 1) |
| cfg_cycle | input | 7 | Total cycle length, clocks |
| cfg_err | output | 1 | Last configuration write was rejected |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| req_addr | input | ADDR_W | Read address |
| req_cs | input | SEL_W | Chip-select index of the request |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | NUM_CS | Active-low chip-select lines |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_rdata | input | DATA_W | Memory read data |
| rd_valid | output | 1 | One-clock read data valid |
| rd_data | output | DATA_W | Captured read data |

## Verification
The bench builds the block with four chip-select lines and 16-bit address and data buses, which are the defaults. Four lines allow two memories to be set up with zero setup and hold, so the continuous-strobe case and the turnaround case can both be run between distinct lines. The other lines hold a zero-pulse record and a maximum record (setup 63, pulse 63, cycle 127), which reach the edges of the field widths. The memory model returns the address XOR a constant, so every returned word shows which address was sampled and on which edge.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int SET_W = 6;
  localparam int PUL_W = 6;
  localparam int CYC_W = 7;

  typedef struct packed {
    logic [CYC_W-1:0] cycle;
    logic [SET_W-1:0] rd_setup;
    logic [PUL_W-1:0] rd_pulse;
    logic [SET_W-1:0] cs_setup;
    logic [PUL_W-1:0] cs_pulse;
  } stm_timing_t;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_RUN} stm_state_e;

  // End of a strobe window: setup plus pulse, a zero pulse counting as one.
  function automatic logic [CYC_W:0] stm_end(input logic [SET_W-1:0] s,
                                             input logic [PUL_W-1:0] p);
    logic [CYC_W:0] pe;
    pe = (p == '0) ? (CYC_W+1)'(1) : (CYC_W+1)'(p);
    return (CYC_W+1)'(s) + pe;
  endfunction
endpackage

// File: rtl/stm_cfg_bank.sv
module stm_cfg_bank
  import stm_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  stm_timing_t       cfg_data,
  output logic              cfg_err,
  input  logic [SEL_W-1:0]  lk_sel,
  output stm_timing_t       lk_data
);
  localparam stm_timing_t DEF_T = '{cycle: CYC_W'(1), default: '0};

  stm_timing_t bank [NUM_CS];
  logic        bad;
  logic        sel_ok;

  // A record is unusable if either strobe window runs past the cycle end.
  assign bad = ({1'b0, cfg_data.cycle} < stm_end(cfg_data.rd_setup, cfg_data.rd_pulse)) ||
               ({1'b0, cfg_data.cycle} < stm_end(cfg_data.cs_setup, cfg_data.cs_pulse));
  assign sel_ok = ({1'b0, cfg_sel} < (SEL_W+1)'(NUM_CS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err <= 1'b0;
      for (int i = 0; i < NUM_CS; i++) bank[i] <= DEF_T;
    end else if (cfg_we) begin
      cfg_err <= bad;
      if (!bad && sel_ok) bank[cfg_sel] <= cfg_data;
    end
  end

  assign lk_data = ({1'b0, lk_sel} < (SEL_W+1)'(NUM_CS)) ? bank[lk_sel] : DEF_T;

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_keep
    // R10: a rejected write leaves the stored record untouched
    p_keep_on_reject_r10: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && bad && cfg_sel == SEL_W'(gi)) |=> (bank[gi] == $past(bank[gi])));
  end
endmodule

// File: rtl/stm_window.sv
module stm_window
  import stm_pkg::*;
(
  input  logic             en,
  input  logic [CYC_W-1:0] t,
  input  logic [SET_W-1:0] setup,
  input  logic [PUL_W-1:0] pulse,
  output logic             act
);
  logic [CYC_W:0] tt;
  logic [CYC_W:0] t_end;

  assign tt    = {1'b0, t};
  assign t_end = stm_end(setup, pulse);
  assign act   = en && (tt >= (CYC_W+1)'(setup)) && (tt < t_end);
endmodule

// File: rtl/stm_seq.sv
module stm_seq
  import stm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEL_W-1:0]  req_cs,
  input  stm_timing_t       lk_data,
  output logic              req_ready,
  output stm_state_e        state_q,
  output logic [CYC_W-1:0]  cnt_q,
  output stm_timing_t       tim_q,
  output stm_state_e        nxt_state,
  output logic [CYC_W-1:0]  nxt_cnt,
  output stm_timing_t       nxt_tim,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [SEL_W-1:0]  nxt_cs
);
  logic [SEL_W-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last;
  logic              accept;
  logic              old_tail;
  logic              need_gap;

  assign last      = (state_q == ST_RUN) &&
                     (({1'b0, cnt_q} + (CYC_W+1)'(1)) == {1'b0, tim_q.cycle});
  assign req_ready = (state_q == ST_IDLE) || last;
  assign accept    = req_valid && req_ready;
  // previous chip select still low on its final clock (zero hold)
  assign old_tail  = (stm_end(tim_q.cs_setup, tim_q.cs_pulse) == {1'b0, tim_q.cycle});
  assign need_gap  = last && (req_cs != cs_q) && old_tail && (lk_data.cs_setup == '0);

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_q;
    nxt_tim   = tim_q;
    nxt_addr  = addr_q;
    nxt_cs    = cs_q;
    if (state_q == ST_GAP) begin
      nxt_state = ST_RUN;
      nxt_cnt   = '0;
    end else if (state_q == ST_RUN && !last) begin
      nxt_cnt = cnt_q + CYC_W'(1);
    end else if (accept) begin
      nxt_tim   = lk_data;
      nxt_addr  = req_addr;
      nxt_cs    = req_cs;
      nxt_cnt   = '0;
      nxt_state = need_gap ? ST_GAP : ST_RUN;
    end else begin
      nxt_state = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tim_q   <= '{cycle: CYC_W'(1), default: '0};
      addr_q  <= '0;
      cs_q    <= '0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= nxt_cnt;
      tim_q   <= nxt_tim;
      addr_q  <= nxt_addr;
      cs_q    <= nxt_cs;
    end
  end

  // R5: the counter never passes the programmed cycle length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> ({1'b0, cnt_q} < {1'b0, tim_q.cycle}));
  // R9: a turnaround clock lasts exactly one clock and starts a cycle
  p_gap_single_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |=> (state_q == ST_RUN && cnt_q == '0));
endmodule

// File: rtl/stm_read_gen.sv
module stm_read_gen
  import stm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [SET_W-1:0]  cfg_rd_setup,
  input  logic [PUL_W-1:0]  cfg_rd_pulse,
  input  logic [SET_W-1:0]  cfg_cs_setup,
  input  logic [PUL_W-1:0]  cfg_cs_pulse,
  input  logic [CYC_W-1:0]  cfg_cycle,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEL_W-1:0]  req_cs,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  stm_timing_t       cfg_data;
  stm_timing_t       lk_data;
  stm_state_e        state_q;
  stm_state_e        nxt_state;
  logic [CYC_W-1:0]  cnt_q;
  logic [CYC_W-1:0]  nxt_cnt;
  stm_timing_t       tim_q;
  stm_timing_t       nxt_tim;
  logic [ADDR_W-1:0] nxt_addr;
  logic [SEL_W-1:0]  nxt_cs;
  logic              nxt_run;
  logic              rd_act;
  logic              cs_act;
  logic [NUM_CS-1:0] cs_vec_n;
  logic              cap;

  assign cfg_data = '{cycle: cfg_cycle, rd_setup: cfg_rd_setup, rd_pulse: cfg_rd_pulse,
                      cs_setup: cfg_cs_setup, cs_pulse: cfg_cs_pulse};

  stm_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cfg_err(cfg_err), .lk_sel(req_cs), .lk_data(lk_data)
  );

  stm_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_cs(req_cs),
    .lk_data(lk_data), .req_ready(req_ready), .state_q(state_q), .cnt_q(cnt_q),
    .tim_q(tim_q), .nxt_state(nxt_state), .nxt_cnt(nxt_cnt), .nxt_tim(nxt_tim),
    .nxt_addr(nxt_addr), .nxt_cs(nxt_cs)
  );

  assign nxt_run = (nxt_state == ST_RUN);

  // Strobe levels for the coming clock, registered below.
  stm_window u_rd_win (
    .en(nxt_run), .t(nxt_cnt), .setup(nxt_tim.rd_setup), .pulse(nxt_tim.rd_pulse),
    .act(rd_act)
  );
  stm_window u_cs_win (
    .en(nxt_run), .t(nxt_cnt), .setup(nxt_tim.cs_setup), .pulse(nxt_tim.cs_pulse),
    .act(cs_act)
  );

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    assign cs_vec_n[gi] = !(cs_act && (nxt_cs == SEL_W'(gi)));
  end

  // Last clock of the read pulse in the running cycle.
  assign cap = (state_q == ST_RUN) &&
               (({1'b0, cnt_q} + (CYC_W+1)'(1)) == stm_end(tim_q.rd_setup, tim_q.rd_pulse));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_n <= 1'b1;
      mem_cs_n <= '1;
      mem_addr <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      mem_rd_n <= !rd_act;
      mem_cs_n <= cs_vec_n;
      if (nxt_run) mem_addr <= nxt_addr;
      rd_valid <= cap;
      if (cap) rd_data <= mem_rdata;
    end
  end

  // R1: no strobe is active while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (mem_rd_n && (&mem_cs_n)));
  // R4: never two memories selected at once
  p_one_cs_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));
  // R9: the turnaround clock drives every strobe high
  p_gap_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> (mem_rd_n && (&mem_cs_n)));
  // R7: returned data always follows a clock with the read strobe low
  p_valid_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!mem_rd_n));
  // R2: the address holds through the cycle after its first clock
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && cnt_q != '0) |-> $stable(mem_addr));
endmodule

// File: tb/tb_stm_read_gen.sv
module tb_stm_read_gen;
  localparam int NCS = 4;
  localparam logic [15:0] KEY = 16'h3C5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_rd_setup = '0, cfg_rd_pulse = '0, cfg_cs_setup = '0, cfg_cs_pulse = '0;
  logic [6:0]  cfg_cycle = '0;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_cs = '0;
  logic [15:0] mem_addr;
  logic [NCS-1:0] mem_cs_n;
  logic        mem_rd_n;
  logic [15:0] mem_rdata;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem_addr ^ KEY;

  stm_read_gen #(.NUM_CS(NCS), .ADDR_W(16), .DATA_W(16)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_rd_setup(cfg_rd_setup),
    .cfg_rd_pulse(cfg_rd_pulse), .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
    .cfg_cycle(cfg_cycle), .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cs(req_cs), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int rs, input int rp, input int css,
                           input int csp, input int cyc, output bit err);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel);
    cfg_rd_setup = 6'(rs); cfg_rd_pulse = 6'(rp);
    cfg_cs_setup = 6'(css); cfg_cs_pulse = 6'(csp); cfg_cycle = 7'(cyc);
    @(negedge clk);
    cfg_we = 1'b0;
    err = cfg_err;
  endtask

  // One isolated read; compares every clock of the cycle plus the clock after.
  task automatic single_read(input int cs, input logic [15:0] a, input int rs, input int rp,
                             input int css, input int csp, input int cyc, input string req);
    int rpe, cspe, b_rd, b_cs, b_oth, b_addr, b_rdy, vpos;
    logic [15:0] vdat;
    bit e_rd, e_cs, e_rdy;
    rpe = (rp == 0) ? 1 : rp;
    cspe = (csp == 0) ? 1 : csp;
    b_rd = 0; b_cs = 0; b_oth = 0; b_addr = 0; b_rdy = 0; vpos = -1; vdat = '0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cs = 2'(cs);
    chk(req_ready == 1'b1, req, "ready before accept (R2)", int'(req_ready), 1);
    for (int k = 0; k <= cyc; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      e_rd  = (k < cyc) && (k >= rs) && (k < rs + rpe);
      e_cs  = (k < cyc) && (k >= css) && (k < css + cspe);
      e_rdy = (k >= cyc - 1);
      if (mem_rd_n != !e_rd) b_rd++;
      if (mem_cs_n[cs] != !e_cs) b_cs++;
      for (int j = 0; j < NCS; j++) if (j != cs && !mem_cs_n[j]) b_oth++;
      if (k < cyc && mem_addr != a) b_addr++;
      if (req_ready != e_rdy) b_rdy++;
      if (rd_valid) begin
        if (vpos == -1) begin vpos = k; vdat = rd_data; end
        else vpos = -2;
      end
    end
    chk(b_rd == 0, req, "read strobe window (R3)", b_rd, 0);
    chk(b_cs == 0, req, "chip-select window (R4)", b_cs, 0);
    chk(b_oth == 0, req, "other lines idle (R4)", b_oth, 0);
    chk(b_addr == 0, req, "address held (R2)", b_addr, 0);
    chk(b_rdy == 0, req, "ready/cycle length (R5)", b_rdy, 0);
    chk(vpos == rs + rpe, req, "data valid clock (R7)", vpos, rs + rpe);
    chk(vdat == (a ^ KEY), req, "data word (R7)", int'(vdat), int'(a ^ KEY));
  endtask

  task automatic t_reset;
    chk(mem_rd_n == 1'b1, "R1", "read strobe", int'(mem_rd_n), 1);
    chk(mem_cs_n == '1, "R1", "chip selects", int'(mem_cs_n), 15);
    chk(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
    chk(cfg_err == 1'b0, "R1", "cfg_err", int'(cfg_err), 0);
  endtask

  // R8: zero setup/hold, same memory, two reads back to back
  task automatic t_same_b2b;
    bit err;
    int b_rd, b_cs, b_addr, vcnt;
    logic [15:0] a0, a1;
    a0 = 16'h1200; a1 = 16'h1201;
    cfg_write(2, 0, 3, 0, 3, 3, err);
    chk(err == 0, "R10", "exact-fit config accepted", int'(err), 0);
    b_rd = 0; b_cs = 0; b_addr = 0; vcnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a0; req_cs = 2'd2;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (n == 0) req_addr = a1;
      if (n == 2) chk(req_ready == 1'b1, "R8", "ready on last clock", int'(req_ready), 1);
      if (n == 3) req_valid = 1'b0;
      if (mem_rd_n != !(n < 6)) b_rd++;
      if (mem_cs_n[2] != !(n < 6)) b_cs++;
      if (n < 3 && mem_addr != a0) b_addr++;
      if (n >= 3 && n < 6 && mem_addr != a1) b_addr++;
      if (rd_valid != (n == 3 || n == 6)) vcnt++;
      if (n == 3 && rd_data != (a0 ^ KEY)) vcnt++;
      if (n == 6 && rd_data != (a1 ^ KEY)) vcnt++;
    end
    chk(b_rd == 0, "R8", "read strobe continuous", b_rd, 0);
    chk(b_cs == 0, "R8", "chip select continuous", b_cs, 0);
    chk(b_addr == 0, "R8", "address per cycle", b_addr, 0);
    chk(vcnt == 0, "R7", "two data returns", vcnt, 0);
  endtask

  // R9: zero setup/hold, switch from memory 0 to memory 1
  task automatic t_diff_b2b;
    bit err;
    int b_c0, b_c1, b_rd, b_gap, vcnt;
    logic [15:0] a0, a1;
    a0 = 16'h0040; a1 = 16'h0080;
    cfg_write(0, 0, 2, 0, 2, 2, err);
    cfg_write(1, 0, 2, 0, 2, 2, err);
    b_c0 = 0; b_c1 = 0; b_rd = 0; b_gap = 0; vcnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a0; req_cs = 2'd0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (n == 0) begin req_addr = a1; req_cs = 2'd1; end
      if (n == 2) req_valid = 1'b0;
      if (mem_cs_n[0] != !(n < 2)) b_c0++;
      if (mem_cs_n[1] != !(n == 3 || n == 4)) b_c1++;
      if (mem_rd_n != !(n != 2 && n < 5)) b_rd++;
      if (n == 2 && (mem_addr != a0 || mem_cs_n != '1)) b_gap++;
      if (rd_valid != (n == 2 || n == 5)) vcnt++;
      if (n == 5 && rd_data != (a1 ^ KEY)) vcnt++;
    end
    chk(b_c0 == 0, "R9", "old line window", b_c0, 0);
    chk(b_c1 == 0, "R9", "new line after turnaround", b_c1, 0);
    chk(b_rd == 0, "R9", "read strobe with turnaround", b_rd, 0);
    chk(b_gap == 0, "R9", "turnaround idle, address kept", b_gap, 0);
    chk(vcnt == 0, "R9", "data returns around turnaround", vcnt, 0);
  endtask

  task automatic t_reject;
    bit err;
    cfg_write(1, 3, 3, 0, 1, 5, err);
    chk(err == 1, "R10", "read window too long rejected", int'(err), 1);
    single_read(1, 16'h0777, 0, 2, 0, 2, 2, "R10 kept record");
    cfg_write(1, 0, 1, 4, 0, 4, err);
    chk(err == 1, "R10", "chip-select window too long rejected", int'(err), 1);
    cfg_write(1, 1, 2, 2, 1, 3, err);
    chk(err == 0, "R10", "valid write clears error", int'(err), 0);
    single_read(1, 16'h0778, 1, 2, 2, 1, 3, "R10 new record");
  endtask

  initial begin
    bit err;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    single_read(0, 16'h0001, 0, 0, 0, 0, 1, "R6 default record");
    cfg_write(3, 2, 0, 1, 0, 4, err);
    single_read(3, 16'h00F3, 2, 0, 1, 0, 4, "R6 zero pulse");
    cfg_write(0, 1, 2, 0, 4, 6, err);
    cfg_write(3, 63, 63, 10, 20, 127, err);
    chk(err == 0, "R11", "maximum record accepted", int'(err), 0);
    single_read(0, 16'hA001, 1, 2, 0, 4, 6, "R3 R5 line 0");
    single_read(3, 16'hB003, 63, 63, 10, 20, 127, "R11 line 3 max");
    single_read(0, 16'hA002, 1, 2, 0, 4, 6, "R11 line 0 again");
    t_same_b2b();
    t_diff_b2b();
    t_reject();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule